// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block is a watchdog timer that software programs through one small control register and one flag register. A prescaled counter runs while the watchdog is enabled. Software restarts the count with a restart strobe. When the count reaches the terminal value that the period-select field picks, the block drives a one-cycle reset pulse and latches a reset flag. Software clears that flag by writing zero to it.

Two changes are protected by a short unlock handshake: turning the watchdog off, and changing its period while it runs. The opening write sets the unlock bit and the run bit together. The closing write has the unlock bit clear and must arrive within four clocks of the opening write. A static level input picks one of two policies. In opt-in mode the watchdog starts stopped and may be switched on freely. In locked mode it always runs, and only its period can be changed, through the handshake.

Top module: `wdt_guarded`

## Requirements
- R1: After reset the control readback holds period select 0 with the unlock bit clear. The run bit reads 0 in opt-in mode (level input 0) and 1 in locked mode (level input 1). The reset pulse and the flag are both 0.
- R2: In opt-in mode, a plain write with the run bit (bit 3 of the control word) set starts a stopped watchdog.
- R3: A write opens the unlock window only if the unlock bit (bit 4) and the run bit (bit 3) are both 1 in that same write. A write with the unlock bit set and the run bit clear opens nothing, and a later closing write is then ignored.
- R4: The closing write has bit 4 clear. It is accepted when it is captured on the 1st to 4th clock after the opening write, and ignored on the 5th or later. Bit 4 of the readback shows 1 while the window is open and clears by itself when the window ends.
- R5: In opt-in mode, a running watchdog stops only when the closing write of a valid handshake carries run = 0. A plain write of run = 0 leaves it running.
- R6: In locked mode the run bit always reads 1. The period select (bits 2:0) changes only through a valid handshake, and the run value in the closing write has no effect.
- R7: A plain write to the period select is ignored while the watchdog runs. It is accepted while the watchdog is stopped in opt-in mode.
- R8: With period select p, a reset pulse comes 2^(BASE_LOG2+p) clocks after the counter restarts, and it lasts exactly one clock. The counter then restarts.
- R9: A restart strobe clears the counter. A strobe in the clock where the count would expire suppresses that pulse.
- R10: The flag sets together with each reset pulse. Writing 0 clears it; writing 1 has no effect.
- R11: Any accepted change of run or period select restarts the counter. A stopped watchdog never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| safety_lvl | input | 1 | Static policy: 0 opt-in, 1 locked |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | PSEL_W+2 | Write data: {unlock, run, period select} |
| ctrl_rdata | output | PSEL_W+2 | Readback: {window open, run, period select} |
| kick | input | 1 | Counter restart strobe |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 1 | Flag write value; only 0 acts |
| wd_rst | output | 1 | One-cycle watchdog reset pulse |
| rst_flag | output | 1 | Sticky watchdog reset flag |

## Verification
The hardest situation to reach is the exact edge of the unlock window. A closing write must land on the fourth clock after the opening write, then on the fifth, so the gap has to be controlled to the clock. The bench's write task always starts on a falling edge, and the idle gap between the two writes is an explicit clock count, so the accepted and rejected cases differ by one cycle. A restart strobe that falls in the expiry clock is placed the same way, by counting clocks from the write that restarted the counter.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  typedef enum logic {
    LVL_OPT_IN = 1'b0,
    LVL_LOCKED = 1'b1
  } wdt_level_e;

  // Terminal count for a period select: 2^(base+sel) - 1.
  function automatic logic [31:0] wdt_limit(input logic [31:0] base_log2,
                                            input logic [31:0] sel);
    return (32'd1 << (base_log2 + sel)) - 32'd1;
  endfunction

endpackage

// File: rtl/wdt_unlock.sv
`timescale 1ns/1ps
module wdt_unlock #(
  parameter int WIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_unlock,
  input  logic wr_run,
  output logic win_open,
  output logic open_evt,
  output logic commit_evt
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  logic [WIN_W-1:0] win_cnt;

  assign win_open   = (win_cnt != '0);
  assign open_evt   = wr_en & wr_unlock & wr_run;
  assign commit_evt = wr_en & ~wr_unlock & win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win_cnt <= '0;
    else if (open_evt)   win_cnt <= WIN_W'(WIN_CYCLES);
    else if (commit_evt) win_cnt <= '0;
    else if (win_open)   win_cnt <= win_cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl #(
  parameter int PSEL_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  wdt_pkg::wdt_level_e     level,
  input  logic                    wr_en,
  input  logic                    wr_run,
  input  logic [PSEL_W-1:0]       wr_psel,
  input  logic                    commit_evt,
  output logic                    run_q,
  output logic [PSEL_W-1:0]       psel_q,
  output logic                    cfg_upd
);
  logic              run_d;
  logic [PSEL_W-1:0] psel_d;
  logic              locked;

  assign locked = (level == wdt_pkg::LVL_LOCKED);

  always_comb begin
    run_d  = run_q;
    psel_d = psel_q;
    if (commit_evt) begin
      if (!locked) run_d = wr_run;
      psel_d = wr_psel;
    end else if (wr_en && !locked) begin
      if (wr_run) run_d = 1'b1;
      if (!run_q) psel_d = wr_psel;
    end
    cfg_upd = (run_d != run_q) || (psel_d != psel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= locked;
      psel_q <= '0;
    end else begin
      run_q  <= run_d;
      psel_q <= psel_d;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
module wdt_timer #(
  parameter int PSEL_W    = 3,
  parameter int BASE_LOG2 = 4,
  parameter int CNT_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  input  logic              cfg_upd,
  input  logic              kick,
  output logic              expire,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              pulse_q
);
  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'(wdt_pkg::wdt_limit(32'(BASE_LOG2), 32'(psel)));
  assign expire = run & (cnt_q == limit) & ~kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expire;
      if (cfg_upd || kick || expire || !run) cnt_q <= '0;
      else                                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_guarded.sv
`timescale 1ns/1ps
module wdt_guarded #(
  parameter int PSEL_W     = 3,
  parameter int BASE_LOG2  = 4,
  parameter int WIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              safety_lvl,
  input  logic              ctrl_wr,
  input  logic [PSEL_W+1:0] ctrl_wdata,
  output logic [PSEL_W+1:0] ctrl_rdata,
  input  logic              kick,
  input  logic              flag_wr,
  input  logic              flag_wdata,
  output logic              wd_rst,
  output logic              rst_flag
);
  localparam int CNT_W = BASE_LOG2 + (2 ** PSEL_W) - 1;

  wdt_pkg::wdt_level_e level;
  logic              wr_unlock, wr_run;
  logic [PSEL_W-1:0] wr_psel;
  logic              win_open, open_evt, commit_evt;
  logic              run_en, cfg_upd, expire, cnt_idle;
  logic [PSEL_W-1:0] psel_sel;
  logic [CNT_W-1:0]  cnt;

  assign level     = wdt_pkg::wdt_level_e'(safety_lvl);
  assign wr_unlock = ctrl_wdata[PSEL_W+1];
  assign wr_run    = ctrl_wdata[PSEL_W];
  assign wr_psel   = ctrl_wdata[PSEL_W-1:0];

  wdt_unlock #(.WIN_CYCLES(WIN_CYCLES)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wr_unlock(wr_unlock),
    .wr_run(wr_run), .win_open(win_open), .open_evt(open_evt),
    .commit_evt(commit_evt)
  );

  wdt_ctrl #(.PSEL_W(PSEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .level(level), .wr_en(ctrl_wr),
    .wr_run(wr_run), .wr_psel(wr_psel), .commit_evt(commit_evt),
    .run_q(run_en), .psel_q(psel_sel), .cfg_upd(cfg_upd)
  );

  wdt_timer #(.PSEL_W(PSEL_W), .BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run_en), .psel(psel_sel),
    .cfg_upd(cfg_upd), .kick(kick), .expire(expire), .cnt_q(cnt),
    .pulse_q(wd_rst)
  );

  assign cnt_idle   = (cnt == '0);
  assign ctrl_rdata = {win_open, run_en, psel_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rst_flag <= 1'b0;
    else if (expire)                 rst_flag <= 1'b1;
    else if (flag_wr && !flag_wdata) rst_flag <= 1'b0;
  end
endmodule

// File: rtl/wdt_guarded_chk.sv
`timescale 1ns/1ps
module wdt_guarded_chk #(
  parameter int PSEL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              safety_lvl,
  input logic              run_en,
  input logic [PSEL_W-1:0] psel_sel,
  input logic              commit_evt,
  input logic              kick,
  input logic              wd_rst,
  input logic              rst_flag,
  input logic              cnt_idle
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wd_rst |=> !wd_rst); // R8
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wd_rst |-> rst_flag); // R10
  AST_LOCKED_RUNS: assert property (@(posedge clk) disable iff (!rst_n) safety_lvl |-> run_en); // R6
  AST_STOP_GUARDED: assert property (@(posedge clk) disable iff (!rst_n) (!safety_lvl && $fell(run_en)) |-> $past(commit_evt)); // R5
  AST_PSEL_GUARDED: assert property (@(posedge clk) disable iff (!rst_n) !$stable(psel_sel) |-> ($past(commit_evt) || !$past(run_en))); // R7
  AST_KICK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) kick |=> !wd_rst); // R9
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !run_en |-> cnt_idle); // R11
endmodule

bind wdt_guarded wdt_guarded_chk #(.PSEL_W(PSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .safety_lvl(safety_lvl), .run_en(run_en),
  .psel_sel(psel_sel), .commit_evt(commit_evt), .kick(kick),
  .wd_rst(wd_rst), .rst_flag(rst_flag), .cnt_idle(cnt_idle)
);

// File: tb/wdt_guarded_bench.sv
`timescale 1ns/1ps
module wdt_guarded_bench;
  localparam int PS_W = 3;
  localparam int BASE = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0, lvl = 1'b0, wr = 1'b0, kick = 1'b0;
  logic            fwr = 1'b0, fdat = 1'b0;
  logic [PS_W+1:0] wdat = '0;
  logic [PS_W+1:0] rdata;
  logic            wdr, flg;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;

  wdt_guarded #(.PSEL_W(PS_W), .BASE_LOG2(BASE), .WIN_CYCLES(4)) u_wdt_guarded (
    .clk(clk), .rst_n(rst_n), .safety_lvl(lvl), .ctrl_wr(wr), .ctrl_wdata(wdat),
    .ctrl_rdata(rdata), .kick(kick), .flag_wr(fwr), .flag_wdata(fdat),
    .wd_rst(wdr), .rst_flag(flg)
  );

  // Behavioural reference model
  int m_en, m_ps, m_win, m_cnt, n_en, n_ps;
  bit m_pulse, m_flag, expire_m, commit_m, open_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = lvl ? 1 : 0; m_ps = 0; m_win = 0; m_cnt = 0; m_pulse = 0; m_flag = 0;
    end else begin
      open_m   = wr && wdat[PS_W+1] && wdat[PS_W];
      commit_m = wr && !wdat[PS_W+1] && (m_win > 0);
      n_en = m_en; n_ps = m_ps;
      if (commit_m) begin
        if (!lvl) n_en = wdat[PS_W];
        n_ps = int'(wdat[PS_W-1:0]);
      end else if (wr && !lvl) begin
        if (wdat[PS_W]) n_en = 1;
        if (m_en == 0) n_ps = int'(wdat[PS_W-1:0]);
      end
      expire_m = (m_en == 1) && (m_cnt == (2 ** (BASE + m_ps)) - 1) && !kick;
      if (n_en != m_en || n_ps != m_ps || kick || expire_m || m_en == 0) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (expire_m) m_flag = 1;
      else if (fwr && !fdat) m_flag = 0;
      m_pulse = expire_m;
      if (open_m) m_win = 4;
      else if (commit_m) m_win = 0;
      else if (m_win > 0) m_win = m_win - 1;
      m_en = n_en; m_ps = n_ps;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R4 model readback", int'(rdata), (m_win > 0 ? 16 : 0) + m_en * 8 + m_ps);
      chk("R8 model pulse", int'(wdr), int'(m_pulse));
      chk("R10 model flag", int'(flg), int'(m_flag));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic u, input logic r, input logic [PS_W-1:0] p);
    wr = 1'b1; wdat = {u, r, p};
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wr_flag(input logic v);
    fwr = 1'b1; fdat = v;
    @(negedge clk);
    fwr = 1'b0;
  endtask

  task automatic do_reset(input logic level);
    cmp_on = 1'b0;
    lvl = level; wr = 0; kick = 0; fwr = 0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    while (wdr !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  int n, pulses;

  initial begin
    // ---- opt-in mode ----
    do_reset(1'b0);
    chk("R1 readback opt-in", int'(rdata), 0);
    chk("R1 pulse low", int'(wdr), 0);
    chk("R1 flag low", int'(flg), 0);

    wr_ctrl(1'b0, 1'b0, 3'd5);
    chk("R7 psel free while stopped", int'(rdata), 5);
    wr_ctrl(1'b1, 1'b0, 3'd2);
    chk("R3 no window without run bit", int'(rdata), 2);
    wr_ctrl(1'b0, 1'b1, 3'd0);
    chk("R2 plain enable", int'(rdata), 8);
    wait_pulse(n);
    chk("R8 period psel0", n, 16);
    chk("R10 flag set", int'(flg), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(wdr), 0);
    wr_flag(1'b1);
    chk("R10 write one ignored", int'(flg), 1);
    wr_flag(1'b0);
    chk("R10 write zero clears", int'(flg), 0);

    wr_ctrl(1'b0, 1'b0, 3'd0);
    chk("R5 plain stop ignored", int'(rdata), 8);
    wr_ctrl(1'b0, 1'b1, 3'd3);
    chk("R7 psel locked while running", int'(rdata), 8);

    wr_ctrl(1'b1, 1'b1, 3'd0);
    chk("R4 window shows open", int'(rdata), 24);
    idle(4);
    chk("R4 window self-clears", int'(rdata), 8);
    wr_ctrl(1'b0, 1'b0, 3'd0);
    chk("R4 late close ignored", int'(rdata), 8);

    wr_ctrl(1'b1, 1'b0, 3'd1);
    chk("R3 unlock without run opens nothing", int'(rdata), 8);
    wr_ctrl(1'b0, 1'b0, 3'd1);
    chk("R3 close without open ignored", int'(rdata), 8);

    wr_ctrl(1'b1, 1'b1, 3'd0);
    idle(3);
    wr_ctrl(1'b0, 1'b0, 3'd6);
    chk("R5 stop on 4th clock accepted", int'(rdata), 6);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wdr) pulses++;
    end
    chk("R11 stopped never pulses", pulses, 0);

    // kick in expiry clock
    wr_ctrl(1'b0, 1'b1, 3'd0);
    idle(15);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    chk("R9 kick suppresses pulse", int'(wdr), 0);
    idle(15);
    chk("R9 no early pulse", int'(wdr), 0);
    idle(1);
    chk("R9 pulse after restart", int'(wdr), 1);

    // config change restarts count
    idle(5);
    wr_ctrl(1'b1, 1'b1, 3'd0);
    wr_ctrl(1'b0, 1'b1, 3'd1);
    chk("R11 period change via handshake", int'(rdata), 9);
    wait_pulse(n);
    chk("R11 restart on change", n, 32);

    // ---- locked mode ----
    do_reset(1'b1);
    chk("R1 readback locked", int'(rdata), 8);
    wr_ctrl(1'b0, 1'b0, 3'd3);
    chk("R6 plain write ignored", int'(rdata), 8);
    wr_ctrl(1'b1, 1'b1, 3'd0);
    idle(1);
    wr_ctrl(1'b0, 1'b0, 3'd2);
    chk("R6 period changed, run held", int'(rdata), 10);
    wait_pulse(n);
    chk("R8 period psel2", n, 64);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule